// File: doc/BRIEF.md
# Status-Coded I2C Master Transmitter

This block sends bytes on an I2C bus as its master. Software works it through four byte-wide registers. A control register requests START and STOP and holds a flag that software can only clear. A data register holds the next byte. A read-only status register holds a code for the last bus event. A divider register sets the SCL rate. The block drives SCL and SDA as open-drain lines: each output enable pulls its line low when high.

Each bus event ends with the engine parked. The flag is set, a fixed status code is loaded and SCL is held low. The bus stays frozen until software clears the flag. What happens next depends on the control bits written with that clear:
- the START request set gives a repeated START;
- otherwise the STOP request set gives a STOP;
- otherwise the byte in the data register goes out.

A bus monitor watches the resolved lines for START and STOP conditions made by any master. A START request waits until the bus is free.

Top module: `i2c_mtx_core`

## Requirements
- R1: After reset both lines are released, the status reads 0xF8, the control register reads 0x00 and the divider reads 4.
- R2: Writing control with the START request (bit 2) while the bus is free produces SDA falling while SCL is high. Then the flag (control bit 0) is set, the status reads 0x08 and the START request clears itself.
- R3: A START request made while the bus is busy puts nothing on the bus until a STOP is seen; the START is then produced.
- R4: While the flag is set, SCL is held low and nothing else happens on the bus.
- R5: Clearing the flag with neither request set sends the data register as 8 bits, MSB first, followed by a released acknowledge bit. SDA changes only while SCL is low, so no START or STOP appears within a byte.
- R6: The first byte after a START or repeated START is the address byte. If it is acknowledged (SDA low on the ninth clock), the flag is set with status 0x18; if not, with status 0x20.
- R7: Any later byte sets the flag with status 0x28 when acknowledged and 0x30 when not.
- R8: Clearing the flag with the STOP request (bit 1) produces SDA rising while SCL is high. The STOP request then clears itself, the flag stays clear, the status reads 0xF8, both lines are released and busy reads 0.
- R9: Clearing the flag with the START request set produces a repeated START with no STOP before it, and then sets the flag with status 0x10.
- R10: Within a byte the SCL period is 4 × (divider + 1) clocks.
- R11: Control bit 7 reads 1 from any START on the bus and returns to 0 at the next STOP, whichever master made them.
- R12: The register addresses are control 0, data 1, status 2 and divider 3.
  - Writing 1 to the flag has no effect.
  - Control bit 3 is a plain read-back bit.
  - Data reads back as written.
  - Writes to status are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The engine is run against a behavioural slave on a wired-AND bus, over several transfers.
- Address and data bytes with differing bit patterns are sent with the slave acknowledging or refusing. This separates the four byte status codes and catches wrong bit order.
- A repeated START mid-transfer shows that no STOP is slipped in.
- Runs at two divider settings check the SCL period on every clock edge.
- A second master holding the bus shows that a START request waits for the STOP.

// File: rtl/i2cmt_pkg.sv
package i2cmt_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  localparam int B_FLAG = 0;
  localparam int B_STO  = 1;
  localparam int B_STA  = 2;
  localparam int B_AUX  = 3;
  localparam int B_BUSY = 7;

  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RSTART   = 8'h10;
  localparam logic [7:0] ST_ADR_ACK  = 8'h18;
  localparam logic [7:0] ST_ADR_NACK = 8'h20;
  localparam logic [7:0] ST_DAT_ACK  = 8'h28;
  localparam logic [7:0] ST_DAT_NACK = 8'h30;
  localparam logic [7:0] ST_IDLE     = 8'hF8;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_HOLD, E_BYTE, E_RSTART, E_STOP
  } eng_st_t;

  // status code after the ninth clock of a byte
  function automatic logic [7:0] byte_status(input logic addr_phase, input logic nack);
    if (addr_phase) return nack ? ST_ADR_NACK : ST_ADR_ACK;
    return nack ? ST_DAT_NACK : ST_DAT_ACK;
  endfunction
endpackage

// File: rtl/i2cmt_qtick.sv
module i2cmt_qtick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + DIV_W'(1);
  end

  // R10: with a nonzero divider, quarter ticks are never adjacent
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/i2cmt_busmon.sv
module i2cmt_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy,
  output logic start_seen,
  output logic stop_seen
);
  logic scl_d, sda_d;

  assign start_seen = scl_d && scl_in && sda_d && !sda_in;
  assign stop_seen  = scl_d && scl_in && !sda_d && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      if (start_seen)     busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
    end
  end

  a_r11_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> busy);
  a_r11_free_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !busy);
endmodule

// File: rtl/i2cmt_engine.sv
module i2cmt_engine
  import i2cmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sta,
  input  logic              sto,
  input  logic              si,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              bus_busy,
  input  logic              sda_in,
  output logic              run,
  output logic              scl_drv,
  output logic              sda_drv,
  output logic              set_si,
  output logic              clr_sta,
  output logic              clr_sto,
  output logic              stat_load,
  output logic [7:0]        stat_code
);
  eng_st_t           st;
  logic [1:0]        q;
  logic [3:0]        bitn;
  logic [BYTE_W-1:0] sh;
  logic              addr_ph;

  // named events
  logic fin, done_start, done_rst, done_byte, done_stop;
  assign fin        = tick && (q == 2'd3);
  assign done_start = (st == E_START)  && fin;
  assign done_rst   = (st == E_RSTART) && fin;
  assign done_byte  = (st == E_BYTE)   && fin && (bitn == 4'd8);
  assign done_stop  = (st == E_STOP)   && fin;

  assign run       = (st == E_START) || (st == E_BYTE) || (st == E_RSTART) || (st == E_STOP);
  assign set_si    = done_start || done_rst || done_byte;
  assign clr_sta   = done_start || done_rst;
  assign clr_sto   = done_stop;
  assign stat_load = set_si || done_stop;
  assign stat_code = done_start ? ST_START :
                     done_rst   ? ST_RSTART :
                     done_byte  ? byte_status(addr_ph, sda_in) : ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      q       <= '0;
      bitn    <= '0;
      sh      <= '0;
      addr_ph <= 1'b0;
      scl_drv <= 1'b0;
      sda_drv <= 1'b0;
    end else begin
      case (st)
        E_IDLE: if (sta && !si && !bus_busy) begin
          st <= E_START;
          q  <= '0;
        end
        E_START: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_drv <= 1'b1;
            2'd2: scl_drv <= 1'b1;
            2'd3: begin st <= E_HOLD; addr_ph <= 1'b1; end
            default: ;
          endcase
        end
        E_HOLD: if (!si) begin
          q <= '0;
          if (sta)      st <= E_RSTART;
          else if (sto) st <= E_STOP;
          else begin
            st   <= E_BYTE;
            sh   <= tx_byte;
            bitn <= '0;
          end
        end
        E_BYTE: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_drv <= (bitn == 4'd8) ? 1'b0 : ~sh[BYTE_W-1];
            2'd1: scl_drv <= 1'b0;
            2'd3: begin
              scl_drv <= 1'b1;
              if (bitn == 4'd8) begin
                st      <= E_HOLD;
                addr_ph <= 1'b0;
              end else begin
                bitn <= bitn + 4'd1;
                sh   <= {sh[BYTE_W-2:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
        E_RSTART: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_drv <= 1'b0;
            2'd1: scl_drv <= 1'b0;
            2'd2: sda_drv <= 1'b1;
            default: begin scl_drv <= 1'b1; st <= E_HOLD; addr_ph <= 1'b1; end
          endcase
        end
        E_STOP: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_drv <= 1'b1;
            2'd1: scl_drv <= 1'b0;
            2'd2: sda_drv <= 1'b0;
            default: st <= E_IDLE;
          endcase
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R5: inside a byte SDA moves only while SCL is pulled low
  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_BYTE && !$stable(sda_drv)) |-> scl_drv);
  // R4: a parked engine with the flag set leaves both lines alone
  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_HOLD && si) |=> ($stable(scl_drv) && $stable(sda_drv)));
endmodule

// File: rtl/i2c_mtx_core.sv
module i2c_mtx_core
  import i2cmt_pkg::*;
#(
  parameter int              DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(4)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic             si_q, sta_q, sto_q, aux_q;
  logic [7:0]       data_q, status_q;
  logic [DIV_W-1:0] div_q;

  logic run, tick, busy, start_seen, stop_seen;
  logic set_si, clr_sta, clr_sto, stat_load;
  logic [7:0] stat_code;

  i2cmt_qtick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  i2cmt_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .busy(busy), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2cmt_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sta(sta_q), .sto(sto_q), .si(si_q),
    .tx_byte(data_q), .bus_busy(busy), .sda_in(sda_in), .run(run),
    .scl_drv(scl_oe), .sda_drv(sda_oe), .set_si(set_si), .clr_sta(clr_sta),
    .clr_sto(clr_sto), .stat_load(stat_load), .stat_code(stat_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q     <= 1'b0;
      sta_q    <= 1'b0;
      sto_q    <= 1'b0;
      aux_q    <= 1'b0;
      data_q   <= '0;
      status_q <= ST_IDLE;
      div_q    <= DIV_RST;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            sta_q <= reg_wdata[B_STA];
            sto_q <= reg_wdata[B_STO];
            aux_q <= reg_wdata[B_AUX];
            si_q  <= si_q & reg_wdata[B_FLAG];
          end
          A_DATA:  data_q <= reg_wdata;
          A_DIV:   div_q  <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (clr_sta)   sta_q    <= 1'b0;
      if (clr_sto)   sto_q    <= 1'b0;
      if (set_si)    si_q     <= 1'b1;
      if (stat_load) status_q <= stat_code;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {busy, 3'b000, aux_q, sta_q, sto_q, si_q};
      A_DATA:  reg_rdata = data_q;
      A_STAT:  reg_rdata = status_q;
      default: reg_rdata = 8'(div_q);
    endcase
  end

  // R4: the flag always comes with SCL held low
  a_r4_flag_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    si_q |-> scl_oe);
  // R2: a freshly raised flag carries one of the event codes
  a_r2_code_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_q) |-> (status_q == ST_START || status_q == ST_RSTART ||
                     status_q == ST_ADR_ACK || status_q == ST_ADR_NACK ||
                     status_q == ST_DAT_ACK || status_q == ST_DAT_NACK));
  // R8: after the STOP completes the bus is released and the status idle
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sto |=> (status_q == ST_IDLE && !scl_oe && !sda_oe && !si_q));
  // R12: a control write never sets the flag
  a_r12_flag_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && !si_q && !set_si) |=> !si_q);
endmodule

// File: tb/i2c_mtx_core_bench.sv
module i2c_mtx_core_bench;
  import i2cmt_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       scl_oe, sda_oe, scl_in, sda_in;
  logic       slv_sda_low, ext_sda_low, ext_scl_low;

  assign scl_in = ~(scl_oe | ext_scl_low);
  assign sda_in = ~(sda_oe | slv_sda_low | ext_sda_low);

  i2c_mtx_core u_i2c_mtx_core (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int div_m = 4;
  bit ack_m = 1'b1;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  int starts = 0, stops = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // behavioural slave and bus model, evaluated on every clock
  bit p_scl = 1'b1, p_sda = 1'b1, live = 1'b0;
  int bcnt = 0, last_rise = 0;
  logic [7:0] sr = 8'h00;
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_scl && scl_in && p_sda && !sda_in) begin
        starts++;
        chk(bcnt <= 1, "R5 START inside byte", bcnt, 0);
        bcnt = 0; live = 1'b1;
      end else if (p_scl && scl_in && !p_sda && sda_in) begin
        stops++;
        chk(bcnt <= 1, "R5 STOP inside byte", bcnt, 0);
        bcnt = 0; live = 1'b0;
      end else if (live && !p_scl && scl_in) begin
        if (bcnt >= 1 && bcnt <= 9)
          chk(cyc - last_rise == 4 * (div_m + 1), "R10 SCL period", cyc - last_rise, 4 * (div_m + 1));
        last_rise = cyc;
        if (bcnt < 8) begin
          sr = {sr[6:0], sda_in};
          bcnt++;
          if (bcnt == 8) got_q.push_back(sr);
        end
      end else if (live && p_scl && !scl_in) begin
        if (bcnt == 8) begin slv_sda_low <= ack_m; bcnt = 9; end
        else if (bcnt == 9) begin slv_sda_low <= 1'b0; bcnt = 0; end
      end
    end
    p_scl = scl_in;
    p_sda = sda_in;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_flag(input string tag);
    logic [7:0] v;
    int k = 0;
    do begin rd(A_CTRL, v); k++; end while (!v[0] && k < 5000);
    chk(v[0], tag, v, 1);
  endtask

  task automatic wait_stop();
    logic [7:0] v;
    int k = 0;
    do begin rd(A_CTRL, v); k++; end while (v[1] && k < 5000);
    chk(v == 8'h00, "R8 STOP request clears, flag and busy low", v, 0);
    rd(A_STAT, v);
    chk(v == ST_IDLE, "R8 status idle after STOP", v, ST_IDLE);
  endtask

  task automatic send(input logic [7:0] b, input bit ackv, input logic [7:0] st, input string tag);
    logic [7:0] v;
    ack_m = ackv;
    wr(A_DATA, b);
    exp_q.push_back(b);
    wr(A_CTRL, 8'h00);
    wait_flag(tag);
    rd(A_STAT, v);
    chk(v == st, tag, v, st);
  endtask

  initial begin
    logic [7:0] v;
    int s0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    slv_sda_low = 1'b0; ext_sda_low = 1'b0; ext_scl_low = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, v); chk(v == 8'hF8, "R1 status after reset", v, 8'hF8);
    rd(A_CTRL, v); chk(v == 8'h00, "R1 control after reset", v, 0);
    rd(A_DIV, v);  chk(v == 8'd4, "R1 divider after reset", v, 4);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    // R12 register behaviour
    wr(A_CTRL, 8'h09);
    rd(A_CTRL, v); chk(v == 8'h08, "R12 flag not settable, aux bit kept", v, 8'h08);
    wr(A_DATA, 8'h3C);
    rd(A_DATA, v); chk(v == 8'h3C, "R12 data readback", v, 8'h3C);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk(v == 8'hF8, "R12 status read-only", v, 8'hF8);
    repeat (20) @(negedge clk);
    chk(!scl_oe && !sda_oe && starts == 0, "R12 no bus activity", starts, 0);
    wr(A_CTRL, 8'h00);

    // R2 START, R6 address acknowledged
    wr(A_DIV, 8'd2); div_m = 2;
    wr(A_CTRL, 8'h04);
    wait_flag("R2 flag after START");
    rd(A_STAT, v); chk(v == ST_START, "R2 status 0x08", v, ST_START);
    rd(A_CTRL, v); chk(v[2] == 1'b0 && v[7], "R2 START request cleared, bus busy", v, 8'h81);
    chk(starts == 1, "R2 START seen on bus", starts, 1);
    chk(scl_oe, "R4 SCL held low with flag", scl_oe, 1);
    send(8'hA4, 1'b1, ST_ADR_ACK, "R6 address ACK 0x18");

    // R4 bus frozen while the flag is set
    repeat (60) @(negedge clk);
    chk(got_q.size() == 1 && scl_oe && !scl_in, "R4 bus frozen", got_q.size(), 1);

    // R7 data bytes
    send(8'h5A, 1'b1, ST_DAT_ACK, "R7 data ACK 0x28");
    send(8'hC3, 1'b0, ST_DAT_NACK, "R7 data NACK 0x30");

    // R9 repeated START
    s0 = stops;
    wr(A_CTRL, 8'h04);
    wait_flag("R9 flag after repeated START");
    rd(A_STAT, v); chk(v == ST_RSTART, "R9 status 0x10", v, ST_RSTART);
    chk(stops == s0 && starts == 2, "R9 no STOP before repeated START", stops, s0);
    send(8'hB2, 1'b0, ST_ADR_NACK, "R6 address NACK 0x20");

    // R8 STOP
    wr(A_CTRL, 8'h02);
    wait_stop();
    chk(stops == s0 + 1 && !scl_oe && !sda_oe, "R8 STOP on bus", stops, s0 + 1);

    // R10 fastest divider
    wr(A_DIV, 8'd0); div_m = 0;
    wr(A_CTRL, 8'h04);
    wait_flag("R10 START at divider 0");
    send(8'h6E, 1'b1, ST_ADR_ACK, "R10 address at divider 0");
    wr(A_CTRL, 8'h02);
    wait_stop();

    // R11 and R3: another master owns the bus
    s0 = stops;
    @(negedge clk) ext_sda_low = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_CTRL, v); chk(v[7], "R11 busy after foreign START", v, 8'h80);
    wr(A_CTRL, 8'h04);
    repeat (100) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R3 no drive while busy", {scl_oe, sda_oe}, 0);
    rd(A_STAT, v); chk(v == ST_IDLE, "R3 status idle while waiting", v, ST_IDLE);
    @(negedge clk) ext_sda_low = 1'b0;
    repeat (2) @(negedge clk);
    chk(stops == s0 + 1, "R11 foreign STOP seen", stops, s0 + 1);
    wait_flag("R3 START after bus frees");
    rd(A_STAT, v); chk(v == ST_START, "R3 status 0x08", v, ST_START);
    wr(A_CTRL, 8'h02);
    wait_stop();

    // R5 byte content and order
    chk(got_q.size() == exp_q.size(), "R5 byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < got_q.size())
        chk(got_q[i] == exp_q[i], "R5 byte MSB first", got_q[i], exp_q[i]);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule